// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This stage sits between a two-wide decoder and two execution pipes of unequal ability: a full main pipe and a secondary pipe that handles only a subset of instruction classes. Each cycle the decoder offers an ordered pair of decoded instructions, an older slot and a younger slot. The stage decides, before any register read, whether the pair can go out together with the older instruction on the main pipe and the younger on the secondary pipe. If it cannot, only the older one issues.

A younger instruction that is refused is not lost. It is captured in a one-entry holdover register and becomes the older instruction of the next cycle. In that cycle the incoming older decode slot serves as its partner. While the holdover is occupied, the incoming younger slot is not consumed, and the decoder offers it again. A downstream stall freezes everything: nothing issues and the holdover keeps its contents.

The pair is refused for any of these reasons: a read-after-write dependence inside the pair, both instructions writing the same register, a younger instruction the secondary pipe cannot execute, or either instruction needing both pipes. When the older slot is empty, a valid younger instruction goes straight to the main pipe without any pairing test.

Top module: `dual_pair_issue`

## Requirements
- R1: Reset empties the holdover. With no valid input after reset, `issue` is 00 and `yng_taken` is 1.
- R2: When every pairing condition holds, `issue` is 11 (bit 0 = main pipe, bit 1 = secondary pipe). `main_tag` carries the older tag and `sec_tag` the younger tag, and `issue` bit 1 never rises without bit 0.
- R3: If the older writes (write enable 1) a nonzero register that either younger source names, `issue` is 01, `yng_stall` is 1, and only the older tag goes to the main pipe.
- R4: Register index 0 never creates a dependence or a same-destination conflict.
- R5: An older instruction whose write enable is 0 creates no dependence.
- R6: When both instructions write the same nonzero register with write enable set, pairing is refused (`issue` 01, `yng_stall` 1).
- R7: A younger instruction whose secondary-capable flag is 0 does not pair.
- R8: An instruction with the needs-both-pipes flag set never pairs, whether it is the older or the younger one. It issues alone on the main pipe.
- R9: A refused younger instruction is the older instruction of the next cycle, partnered with the incoming older slot. In that cycle `yng_taken` is 0.
- R10: If the effective older slot is invalid, a valid younger instruction issues on the main pipe alone (`issue` 01, `yng_stall` 0) whatever its flags or registers.
- R11: While `dn_stall` is 1, `issue` is 00, `yng_stall` and `yng_taken` are 0, and the holdover keeps its contents.
- R12: `yng_taken` is 1 exactly when `dn_stall` is 0 and the holdover is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dn_stall | input | 1 | Downstream backpressure; freezes the stage |
| o_vld | input | 1 | Older decode slot valid |
| o_dst | input | 5 | Older destination register index |
| o_src_a | input | 5 | Older first source index |
| o_src_b | input | 5 | Older second source index |
| o_wen | input | 1 | Older writes its destination |
| o_sec_ok | input | 1 | Older is executable by the secondary pipe |
| o_dual | input | 1 | Older needs both pipes |
| o_tag | input | 4 | Older instruction tag |
| y_vld | input | 1 | Younger decode slot valid |
| y_dst | input | 5 | Younger destination register index |
| y_src_a | input | 5 | Younger first source index |
| y_src_b | input | 5 | Younger second source index |
| y_wen | input | 1 | Younger writes its destination |
| y_sec_ok | input | 1 | Younger is executable by the secondary pipe |
| y_dual | input | 1 | Younger needs both pipes |
| y_tag | input | 4 | Younger instruction tag |
| issue | output | 2 | Bit 0 main pipe fires, bit 1 secondary pipe fires |
| main_tag | output | 4 | Tag sent to the main pipe |
| sec_tag | output | 4 | Tag sent to the secondary pipe |
| yng_stall | output | 1 | Effective younger refused and captured for next cycle |
| yng_taken | output | 1 | Incoming younger decode slot consumed this cycle |

## Verification
Two events can fall in the same cycle. A held instruction can be issued as the older slot while its new partner is refused and captured, so the holdover releases and refills at one edge. A downstream stall can also arrive while the holdover is occupied. The table provokes the first through chains of refusals of different kinds (both-pipes after not-capable, then an empty partner). It provokes the second by raising the stall right after a refusal and then releasing it. The result is judged by the tags that reach each pipe on the following cycles: the frozen instruction must reappear as the main-pipe tag, and the younger decode slot must stay unconsumed.

// File: rtl/pair_pkg.sv
package pair_pkg;
    parameter int REG_W = 5;
    parameter int TAG_W = 4;

    typedef struct packed {
        logic             vld;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] src_a;
        logic [REG_W-1:0] src_b;
        logic             wen;
        logic             sec_ok;
        logic             dual;
        logic [TAG_W-1:0] tag;
    } slot_t;

    typedef struct packed {
        slot_t hold;
    } state_t;
endpackage

// File: rtl/pair_slot_mux.sv
module pair_slot_mux
    import pair_pkg::*;
(
    input  slot_t hold,
    input  slot_t in_old,
    input  slot_t in_yng,
    output slot_t e_old,
    output slot_t e_yng
);
    // A held instruction takes the older position; the incoming older slot becomes its partner.
    always_comb begin
        if (hold.vld) begin
            e_old = hold;
            e_yng = in_old;
        end else begin
            e_old = in_old;
            e_yng = in_yng;
        end
    end
endmodule

// File: rtl/pair_hazard_chk.sv
module pair_hazard_chk
    import pair_pkg::*;
(
    input  slot_t e_old,
    input  slot_t e_yng,
    output logic  pair_ok
);
    localparam logic [REG_W-1:0] ZERO_REG = '0;

    logic old_writes;
    logic raw_hit;
    logic waw_hit;
    logic class_ok;

    always_comb begin
        old_writes = e_old.wen && (e_old.dst != ZERO_REG);
        raw_hit    = old_writes && ((e_yng.src_a == e_old.dst) || (e_yng.src_b == e_old.dst));
        waw_hit    = old_writes && e_yng.wen && (e_yng.dst == e_old.dst);
        class_ok   = e_yng.sec_ok && !e_yng.dual && !e_old.dual;
        pair_ok    = e_old.vld && e_yng.vld && class_ok && !raw_hit && !waw_hit;
    end
endmodule

// File: rtl/dual_pair_issue.sv
module dual_pair_issue
    import pair_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dn_stall,
    input  logic             o_vld,
    input  logic [REG_W-1:0] o_dst,
    input  logic [REG_W-1:0] o_src_a,
    input  logic [REG_W-1:0] o_src_b,
    input  logic             o_wen,
    input  logic             o_sec_ok,
    input  logic             o_dual,
    input  logic [TAG_W-1:0] o_tag,
    input  logic             y_vld,
    input  logic [REG_W-1:0] y_dst,
    input  logic [REG_W-1:0] y_src_a,
    input  logic [REG_W-1:0] y_src_b,
    input  logic             y_wen,
    input  logic             y_sec_ok,
    input  logic             y_dual,
    input  logic [TAG_W-1:0] y_tag,
    output logic [1:0]       issue,
    output logic [TAG_W-1:0] main_tag,
    output logic [TAG_W-1:0] sec_tag,
    output logic             yng_stall,
    output logic             yng_taken
);
    localparam slot_t EMPTY_SLOT = '0;

    slot_t  in_old, in_yng, e_old, e_yng;
    logic   pair_ok;
    state_t st_d, st_q;
    logic   hold_vld;

    assign in_old = '{vld: o_vld, dst: o_dst, src_a: o_src_a, src_b: o_src_b,
                      wen: o_wen, sec_ok: o_sec_ok, dual: o_dual, tag: o_tag};
    assign in_yng = '{vld: y_vld, dst: y_dst, src_a: y_src_a, src_b: y_src_b,
                      wen: y_wen, sec_ok: y_sec_ok, dual: y_dual, tag: y_tag};
    assign hold_vld = st_q.hold.vld;

    pair_slot_mux u_mux (
        .hold   (st_q.hold),
        .in_old (in_old),
        .in_yng (in_yng),
        .e_old  (e_old),
        .e_yng  (e_yng)
    );

    pair_hazard_chk u_haz (
        .e_old   (e_old),
        .e_yng   (e_yng),
        .pair_ok (pair_ok)
    );

    always_comb begin
        st_d      = st_q;
        issue     = 2'b00;
        main_tag  = '0;
        sec_tag   = '0;
        yng_stall = 1'b0;
        yng_taken = 1'b0;
        if (!dn_stall) begin
            yng_taken = !st_q.hold.vld;
            st_d.hold = EMPTY_SLOT;
            if (e_old.vld) begin
                issue[0] = 1'b1;
                main_tag = e_old.tag;
                if (pair_ok) begin
                    issue[1] = 1'b1;
                    sec_tag  = e_yng.tag;
                end else if (e_yng.vld) begin
                    yng_stall = 1'b1;
                    st_d.hold = e_yng;
                end
            end else if (e_yng.vld) begin
                // Empty older position: promote without any pairing test.
                issue[0] = 1'b1;
                main_tag = e_yng.tag;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/dual_pair_issue_chk.sv
module dual_pair_issue_chk
    import pair_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             dn_stall,
    input logic             hold_vld,
    input logic [REG_W-1:0] o_dst,
    input logic             o_wen,
    input logic             o_dual,
    input logic [REG_W-1:0] y_src_a,
    input logic [REG_W-1:0] y_src_b,
    input logic             y_sec_ok,
    input logic             y_dual,
    input logic [1:0]       issue,
    input logic             yng_stall,
    input logic             yng_taken
);
    assert_sec_needs_main_R2: assert property (@(posedge clk) disable iff (!rst_n)
        issue[1] |-> issue[0]);

    assert_no_raw_pair_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_vld && issue == 2'b11) |->
            !(o_wen && o_dst != '0 && (y_src_a == o_dst || y_src_b == o_dst)));

    assert_refuse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        yng_stall |-> issue == 2'b01);

    assert_class_pair_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold_vld && issue == 2'b11) |-> (!o_dual && !y_dual && y_sec_ok));

    assert_hold_next_R9: assert property (@(posedge clk) disable iff (!rst_n)
        yng_stall |=> !yng_taken);

    assert_freeze_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dn_stall |-> (issue == 2'b00 && !yng_taken && !yng_stall));

    assert_freeze_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        dn_stall |=> hold_vld == $past(hold_vld));
endmodule

bind dual_pair_issue dual_pair_issue_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dn_stall  (dn_stall),
    .hold_vld  (hold_vld),
    .o_dst     (o_dst),
    .o_wen     (o_wen),
    .o_dual    (o_dual),
    .y_src_a   (y_src_a),
    .y_src_b   (y_src_b),
    .y_sec_ok  (y_sec_ok),
    .y_dual    (y_dual),
    .issue     (issue),
    .yng_stall (yng_stall),
    .yng_taken (yng_taken)
);

// File: tb/dual_pair_issue_tb.sv
module dual_pair_issue_tb;
    import pair_pkg::*;

    typedef struct packed {
        slot_t      o;
        slot_t      y;
        logic       st;
        logic [1:0] ei;
        logic       es;
        logic       et;
        logic [3:0] em;
        logic [3:0] esc;
        logic [3:0] rq;
    } vec_t;

    function automatic slot_t ins(input logic v, input int d, input int a, input int b,
                                  input logic w, input logic s, input logic du, input int t);
        slot_t r;
        r.vld = v; r.dst = d[4:0]; r.src_a = a[4:0]; r.src_b = b[4:0];
        r.wen = w; r.sec_ok = s; r.dual = du; r.tag = t[3:0];
        return r;
    endfunction

    localparam int NV = 16;
    localparam vec_t TBL [NV] = '{
        '{ins(1,1,2,3,1,1,0,1),   ins(1,4,5,6,1,1,0,2),   0, 2'b11, 0, 1, 1, 2, 2},   // R2 independent
        '{ins(1,7,2,3,1,1,0,3),   ins(1,8,7,6,1,1,0,4),   0, 2'b01, 1, 1, 3, 0, 3},   // R3 raw on src_a
        '{ins(1,9,1,2,1,1,0,5),   ins(1,1,1,1,1,1,0,6),   0, 2'b11, 0, 0, 4, 5, 9},   // R9 held tag4 + tag5
        '{ins(1,0,1,2,1,1,0,6),   ins(1,9,0,0,1,1,0,7),   0, 2'b11, 0, 1, 6, 7, 4},   // R4 index zero
        '{ins(1,3,1,2,0,1,0,8),   ins(1,5,3,3,1,1,0,9),   0, 2'b11, 0, 1, 8, 9, 5},   // R5 no write
        '{ins(1,10,1,2,1,1,0,10), ins(1,10,3,4,1,1,0,11), 0, 2'b01, 1, 1, 10, 0, 6},  // R6 same dst
        '{ins(1,12,1,2,1,1,0,12), ins(1,13,1,2,1,1,0,13), 1, 2'b00, 0, 0, 0, 0, 11},  // R11 frozen
        '{ins(1,12,1,2,1,1,0,12), ins(1,13,1,2,1,1,0,13), 0, 2'b11, 0, 0, 11, 12, 11},// R11 resume tag11
        '{ins(1,14,1,2,1,1,0,13), ins(1,15,1,2,1,0,0,14), 0, 2'b01, 1, 1, 13, 0, 7},  // R7 not capable
        '{ins(1,16,1,2,1,1,1,15), ins(1,1,1,1,1,1,0,0),   0, 2'b01, 1, 0, 14, 0, 8},  // R8 partner dual
        '{ins(0,0,0,0,0,0,0,0),   ins(1,1,1,1,1,1,0,0),   0, 2'b01, 0, 0, 15, 0, 8},  // R8 dual alone
        '{ins(0,0,0,0,0,0,0,0),   ins(1,5,5,5,1,0,1,3),   0, 2'b01, 0, 1, 3, 0, 10},  // R10 promote
        '{ins(0,0,0,0,0,0,0,0),   ins(0,0,0,0,0,0,0,0),   0, 2'b00, 0, 1, 0, 0, 12},  // R12 idle
        '{ins(1,17,1,2,1,1,1,1),  ins(1,18,3,4,1,1,0,2),  0, 2'b01, 1, 1, 1, 0, 8},   // R8 older dual
        '{ins(1,19,1,2,1,1,0,5),  ins(1,20,1,2,1,1,0,6),  1, 2'b00, 0, 0, 0, 0, 11},  // R11 frozen hold
        '{ins(0,0,0,0,0,0,0,0),   ins(1,20,1,2,1,1,0,6),  0, 2'b01, 0, 0, 2, 0, 11}   // R11 kept tag2
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dn_stall = 1'b0;
    slot_t o_s = '0;
    slot_t y_s = '0;
    logic [1:0] issue;
    logic [3:0] main_tag, sec_tag;
    logic yng_stall, yng_taken;
    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #4 clk = ~clk;

    dual_pair_issue u_dut (
        .clk(clk), .rst_n(rst_n), .dn_stall(dn_stall),
        .o_vld(o_s.vld), .o_dst(o_s.dst), .o_src_a(o_s.src_a), .o_src_b(o_s.src_b),
        .o_wen(o_s.wen), .o_sec_ok(o_s.sec_ok), .o_dual(o_s.dual), .o_tag(o_s.tag),
        .y_vld(y_s.vld), .y_dst(y_s.dst), .y_src_a(y_s.src_a), .y_src_b(y_s.src_b),
        .y_wen(y_s.wen), .y_sec_ok(y_s.sec_ok), .y_dual(y_s.dual), .y_tag(y_s.tag),
        .issue(issue), .main_tag(main_tag), .sec_tag(sec_tag),
        .yng_stall(yng_stall), .yng_taken(yng_taken)
    );

    task automatic check(input int rq, input logic [1:0] ei, input logic es, input logic et,
                         input logic [3:0] em, input logic [3:0] esc);
        logic ok;
        ok = (issue === ei) && (yng_stall === es) && (yng_taken === et);
        if (ei[0] && main_tag !== em) ok = 1'b0;
        if (ei[1] && sec_tag !== esc) ok = 1'b0;
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL R%0d: got issue=%b stall=%b taken=%b main=%0d sec=%0d exp issue=%b stall=%b taken=%b main=%0d sec=%0d",
                     rq, issue, yng_stall, yng_taken, main_tag, sec_tag, ei, es, et, em, esc);
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got hung run exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(1, 2'b00, 0, 1, 0, 0);               // R1 reset state
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            o_s = TBL[i].o; y_s = TBL[i].y; dn_stall = TBL[i].st;
            #2;
            check(int'(TBL[i].rq), TBL[i].ei, TBL[i].es, TBL[i].et, TBL[i].em, TBL[i].esc);
        end
        // R1: reset empties a filled holdover
        @(negedge clk);
        dn_stall = 1'b0;
        o_s = ins(1,7,1,2,1,1,0,3); y_s = ins(1,8,7,7,1,1,0,4);
        #2;
        check(3, 2'b01, 1, 1, 3, 0);               // R3 refusal fills holdover
        @(negedge clk);
        rst_n = 1'b0;
        o_s = '0; y_s = '0;
        @(negedge clk);
        rst_n = 1'b1;
        #2;
        check(1, 2'b00, 0, 1, 0, 0);               // R1 holdover cleared
        // R10: promotion ignores dependence on an invalid older slot
        @(negedge clk);
        o_s = ins(0,6,1,2,1,1,0,9); y_s = ins(1,6,6,6,1,1,0,10);
        #2;
        check(10, 2'b01, 0, 1, 10, 0);             // R10 promoted despite match
        @(negedge clk);
        o_s = '0; y_s = '0;
        #2;
        check(12, 2'b00, 0, 1, 0, 0);              // R12 nothing held
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule